// File: doc/BRIEF.md
# Serial Flash Page-Program Writer

This unit writes data into a serial NOR flash over a four-wire SPI link. Software first loads the instruction byte and the target address through a small word-addressed register bus. It can then start either of two program frames. The first is a single-byte program that sends one byte held in a byte register. The second is a full-page program that sends 128 bytes gathered in an internal page buffer. Every frame is one continuous chip-select period: the instruction byte, then the address (three bytes, or four in wide-address mode), then the data.

Page mode must be switched on with an enable handshake. Software sets the enable bit, then polls it. The bit reads back as 1 only once the buffer fill pointer has been cleared and the link is idle. Software then pushes 32 little-endian words into the page port and sets the start bit, which reads back as 1 until the frame has left the pins. If the buffer is not full when a page program is requested, the unit rejects the request and raises a sticky error flag instead of sending a frame.

The bus follows valid/ready rules for writes. A write completes on a clock edge where `bus_valid`, `bus_write` and `bus_ready` are all high. `bus_ready` drops for every write while a frame is running, so a frame always uses stable settings. It also drops for page-port writes while the buffer holds 128 bytes. The master must then hold its request until `bus_ready` rises. Reads are combinational on `bus_addr` and need no handshake.

Top module: `pp_write_unit`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0 and `spi_mosi` is 0, and every register (word addresses 0 to 9) reads 0.
- R2: Writing 1 to bit 0 of CFG (address 1) clears the page fill pointer. That bit reads back 1 from the next cycle on while the link is idle. Writing 0 makes it read back 0.
- R3: Each accepted write to the page port (address 8) while page mode is on appends four bytes. Bits 7:0 form the earliest byte in flash order and bits 31:24 the latest.
- R4: In page mode with 3-byte addressing, a start sends 132 bytes within a single `spi_cs_n` low period. The order is the instruction byte from OPC (address 2), then address bits 23:16, 15:8 and 7:0 from registers 5, 4 and 3, then the 128 buffered bytes.
- R5: With CFG bit 1 set, the address field is four bytes, and bits 31:24 from register 6 are sent first. A page frame is then 133 bytes and a single-byte frame is 6 bytes.
- R6: With page mode off, a start sends the instruction byte, the address and the one byte held in register 7: 5 bytes in 3-byte address mode.
- R7: Writing 1 to bit 4 of CMD (address 0) starts a frame. That bit reads 1 from the cycle after the write until `spi_cs_n` returns high, and reads 0 afterwards.
- R8: A page-mode start with fewer than 128 bytes loaded sends no frame and sets bit 0 of STATUS (address 9). Writing 1 to that bit clears it.
- R9: `bus_ready` is 0 for any write while a frame is running, and for page-port writes while the buffer holds 128 bytes.
- R10: The link uses SPI mode 0. `spi_sclk` is low whenever `spi_cs_n` is high, bits go out most significant first, `spi_mosi` is stable while `spi_sclk` is high, and one bit lasts 2*HALF_PERIOD clock cycles.
- R11: A completed page frame empties the buffer, so a second page start with no new data is rejected as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Write request valid |
| bus_ready | output | 1 | Write request accepted on this edge if valid |
| bus_write | input | 1 | Request is a write |
| bus_addr | input | 4 | Word register address (also selects read data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
Page frames are sent with two different seeded byte patterns, one in 3-byte and one in 4-byte address mode. A swapped byte lane, a wrong address byte order or a dropped byte therefore shows up at a distinct frame position. Single-byte frames in both address widths separate the frame-length choice from the address-width choice. Short fills, a back-to-back page start and pushes into a full buffer test the rejection and stall paths. The bit period and the idle clock level are measured on the pins.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int BUS_AW = 4;
  localparam int BUS_DW = 32;

  typedef enum logic [BUS_AW-1:0] {
    REG_CMD  = 4'd0,
    REG_CFG  = 4'd1,
    REG_OPC  = 4'd2,
    REG_AD0  = 4'd3,
    REG_AD1  = 4'd4,
    REG_AD2  = 4'd5,
    REG_AD3  = 4'd6,
    REG_BYTE = 4'd7,
    REG_PAGE = 4'd8,
    REG_STAT = 4'd9
  } reg_sel_e;

  localparam int CMD_GO_BIT  = 4;
  localparam int CFG_BUF_BIT = 0;
  localparam int CFG_A4_BIT  = 1;
  localparam int STAT_ERR_BIT = 0;
endpackage

// File: rtl/pp_page_buf.sv
module pp_page_buf #(
  parameter int PAGE_BYTES = 128,
  parameter int WORD_BYTES = 4,
  localparam int WORDS = PAGE_BYTES / WORD_BYTES,
  localparam int IDX_W = $clog2(PAGE_BYTES),
  localparam int LANE_W = $clog2(WORD_BYTES),
  localparam int WP_W = $clog2(WORDS + 1),
  localparam int LVL_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    push,
  input  logic [8*WORD_BYTES-1:0] push_word,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [7:0]              rd_byte,
  output logic [LVL_W-1:0]        level,
  output logic                    full
);
  logic [8*WORD_BYTES-1:0] mem [WORDS];
  logic [WP_W-1:0] wp_q;
  logic [7:0] lanes [WORD_BYTES];
  logic [IDX_W-LANE_W-1:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= '0;
    else if (clear) wp_q <= '0;
    else if (push && !full) wp_q <= wp_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push && !full && !clear) mem[wp_q[WP_W-2:0]] <= push_word;
  end

  assign rd_word = rd_idx[IDX_W-1:LANE_W];
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign lanes[g] = mem[rd_word][8*g +: 8];
  end
  assign rd_byte = lanes[rd_idx[LANE_W-1:0]];

  assign level = LVL_W'(wp_q) * LVL_W'(WORD_BYTES);
  assign full  = (wp_q == WP_W'(WORDS));

  // R9
  push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(PAGE_BYTES));
endmodule

// File: rtl/pp_spi_tx.sv
module pp_spi_tx #(
  parameter int HALF_PERIOD = 2,
  parameter int LEN_W = 8,
  localparam int DIV_W = $clog2(HALF_PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] nbytes,
  input  logic [7:0]       byte_val,
  output logic [LEN_W-1:0] byte_idx,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi
);
  logic             busy_q, sclk_q, done_q;
  logic [2:0]       bit_q;
  logic [LEN_W-1:0] idx_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      bit_q  <= 3'd7;
      idx_q  <= '0;
      div_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          bit_q  <= 3'd7;
          div_q  <= '0;
          sclk_q <= 1'b0;
        end
      end else if (div_q == DIV_W'(HALF_PERIOD - 1)) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd0) begin
            bit_q <= 3'd7;
            if (idx_q + 1'b1 == nbytes) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            bit_q <= bit_q - 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign byte_idx = idx_q;
  assign busy = busy_q;
  assign done = done_q;
  assign sclk = sclk_q;
  assign cs_n = ~busy_q;
  assign mosi = busy_q & byte_val[bit_q];

  // R10
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R10
  data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R7
  select_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(start));
endmodule

// File: rtl/pp_write_unit.sv
module pp_write_unit
  import pp_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int HALF_PERIOD = 2,
  localparam int HDR_MAX = 5,
  localparam int LEN_W = $clog2(PAGE_BYTES + HDR_MAX + 1),
  localparam int IDX_W = $clog2(PAGE_BYTES),
  localparam int LVL_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi
);
  reg_sel_e         sel;
  logic             wr, go_req, tx_start, tx_busy, tx_done;
  logic [7:0]       opc_q, byte_q, tx_byte, buf_byte;
  logic [3:0][7:0]  adr_q;
  logic             a4_q, buf_req_q, buf_ack_q, err_q;
  logic             buf_clear, buf_push, buf_full;
  logic [LVL_W-1:0] buf_level;
  logic [LEN_W-1:0] hdr_len, frame_len, tx_idx;
  logic [1:0]       adr_sel;

  assign sel = reg_sel_e'(bus_addr);
  assign bus_ready = !(bus_write && (tx_busy || (sel == REG_PAGE && buf_full)));
  assign wr = bus_valid && bus_write && bus_ready;
  assign go_req = wr && (sel == REG_CMD) && bus_wdata[CMD_GO_BIT];
  assign tx_start = go_req && (!buf_ack_q || buf_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q     <= '0;
      byte_q    <= '0;
      adr_q     <= '0;
      a4_q      <= 1'b0;
      buf_req_q <= 1'b0;
      buf_ack_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (!tx_busy) buf_ack_q <= buf_req_q;
      if (go_req && buf_ack_q && !buf_full) err_q <= 1'b1;
      else if (wr && sel == REG_STAT && bus_wdata[STAT_ERR_BIT]) err_q <= 1'b0;
      if (wr) begin
        unique case (sel)
          REG_CFG: begin
            buf_req_q <= bus_wdata[CFG_BUF_BIT];
            a4_q      <= bus_wdata[CFG_A4_BIT];
          end
          REG_OPC:  opc_q    <= bus_wdata[7:0];
          REG_AD0:  adr_q[0] <= bus_wdata[7:0];
          REG_AD1:  adr_q[1] <= bus_wdata[7:0];
          REG_AD2:  adr_q[2] <= bus_wdata[7:0];
          REG_AD3:  adr_q[3] <= bus_wdata[7:0];
          REG_BYTE: byte_q   <= bus_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  assign buf_clear = (wr && sel == REG_CFG) || (tx_done && buf_ack_q);
  assign buf_push  = wr && (sel == REG_PAGE) && buf_ack_q;

  assign hdr_len   = a4_q ? LEN_W'(5) : LEN_W'(4);
  assign frame_len = hdr_len + (buf_ack_q ? LEN_W'(PAGE_BYTES) : LEN_W'(1));
  assign adr_sel   = 2'(hdr_len - 1'b1 - tx_idx);

  always_comb begin
    if (tx_idx == '0) tx_byte = opc_q;
    else if (tx_idx < hdr_len) tx_byte = adr_q[adr_sel];
    else tx_byte = buf_ack_q ? buf_byte : byte_q;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      REG_CMD:  bus_rdata[CMD_GO_BIT] = tx_busy;
      REG_CFG: begin
        bus_rdata[CFG_BUF_BIT] = buf_ack_q;
        bus_rdata[CFG_A4_BIT]  = a4_q;
      end
      REG_OPC:  bus_rdata[7:0] = opc_q;
      REG_AD0:  bus_rdata[7:0] = adr_q[0];
      REG_AD1:  bus_rdata[7:0] = adr_q[1];
      REG_AD2:  bus_rdata[7:0] = adr_q[2];
      REG_AD3:  bus_rdata[7:0] = adr_q[3];
      REG_BYTE: bus_rdata[7:0] = byte_q;
      REG_STAT: bus_rdata[STAT_ERR_BIT] = err_q;
      default: ;
    endcase
  end

  pp_page_buf #(.PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(BUS_DW / 8)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(buf_clear), .push(buf_push),
    .push_word(bus_wdata), .rd_idx(IDX_W'(tx_idx - hdr_len)),
    .rd_byte(buf_byte), .level(buf_level), .full(buf_full)
  );

  pp_spi_tx #(.HALF_PERIOD(HALF_PERIOD), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .nbytes(frame_len),
    .byte_val(tx_byte), .byte_idx(tx_idx), .busy(tx_busy), .done(tx_done),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi)
  );

  // R2
  enable_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_ack_q) |-> $past(!tx_busy && buf_level == '0));
  // R8
  short_fill_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(go_req && buf_ack_q && !buf_full) && spi_cs_n));
  // R9
  stall_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && bus_write) |-> !bus_ready);
endmodule

// File: tb/pp_write_unit_bench.sv
`timescale 1ns/1ps
module pp_write_unit_bench;
  localparam int HALF = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_ready;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pp_write_unit #(.PAGE_BYTES(128), .HALF_PERIOD(HALF)) u_pp_write_unit (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi)
  );

  // flash-side monitor
  logic [7:0] rx [0:139];
  logic [7:0] sh = '0;
  int bitc = 0, nb = 0, frames = 0, last_len = 0;
  always @(posedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      if (nb != 0 || bitc != 0) begin
        frames = frames + 1;
        last_len = nb;
      end
      nb = 0;
      bitc = 0;
    end else begin
      sh = {sh[6:0], spi_mosi};
      bitc = bitc + 1;
      if (bitc == 8) begin
        if (nb < 140) rx[nb] = sh;
        nb = nb + 1;
        bitc = 0;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_write = 1'b1; bus_valid = 1'b1;
    #1;
    while (!bus_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic br(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 6000; i++) begin
      br(4'd0, v);
      if (!v[4]) break;
    end
  endtask

  task automatic set_hdr(input logic [7:0] opc, input logic [31:0] adr);
    bw(4'd2, {24'd0, opc});
    for (int i = 0; i < 4; i++) bw(4'(3 + i), {24'd0, adr[8*i +: 8]});
  endtask

  task automatic fill(input int words, input logic [7:0] seed);
    for (int w = 0; w < words; w++)
      bw(4'd8, {8'(4*w+3) ^ seed, 8'(4*w+2) ^ seed, 8'(4*w+1) ^ seed, 8'(4*w) ^ seed});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(spi_cs_n === 1'b1, "R1 cs_n", 32'(spi_cs_n), 1);
    chk(spi_sclk === 1'b0, "R1 sclk", 32'(spi_sclk), 0);
    chk(spi_mosi === 1'b0, "R1 mosi", 32'(spi_mosi), 0);
    for (int a = 0; a < 10; a++) begin
      br(4'(a), v);
      chk(v === 32'd0, "R1 register", v, 0);
    end
  endtask

  task automatic t_enable();
    logic [31:0] v;
    bw(4'd1, 32'h1);
    br(4'd1, v);
    chk(v[0] === 1'b1, "R2 enable readback", v, 1);
    bw(4'd1, 32'h0);
    br(4'd1, v);
    chk(v[0] === 1'b0, "R2 disable readback", v, 0);
  endtask

  task automatic t_page(input bit a4, input logic [7:0] seed, input logic [31:0] adr);
    logic [31:0] v;
    int f0, hdr;
    hdr = a4 ? 5 : 4;
    set_hdr(8'h02, adr);
    bw(4'd1, {30'd0, a4, 1'b1});
    fill(32, seed);
    // R9: 33rd word stalls
    @(negedge clk);
    bus_addr = 4'd8; bus_write = 1'b1; bus_valid = 1'b1; #1;
    chk(bus_ready === 1'b0, "R9 full page stall", 32'(bus_ready), 0);
    bus_valid = 1'b0; bus_write = 1'b0;
    f0 = frames;
    bw(4'd0, 32'h10);
    br(4'd0, v);
    chk(v[4] === 1'b1, "R7 busy during frame", v, 32'h10);
    @(negedge clk);
    bus_addr = 4'd2; bus_write = 1'b1; bus_valid = 1'b1; #1;
    chk(bus_ready === 1'b0, "R9 write stalled in frame", 32'(bus_ready), 0);
    bus_valid = 1'b0; bus_write = 1'b0;
    wait_idle();
    br(4'd0, v);
    chk(v[4] === 1'b0 && spi_cs_n === 1'b1, "R7 cleared at end", v, 0);
    chk(frames == f0 + 1, "R4 single select period", 32'(frames - f0), 1);
    chk(last_len == hdr + 128, a4 ? "R5 page frame length" : "R4 page frame length", 32'(last_len), 32'(hdr + 128));
    chk(rx[0] === 8'h02, "R4 opcode first", 32'(rx[0]), 2);
    for (int j = 0; j < hdr - 1; j++)
      chk(rx[1+j] === adr[8*(hdr-2-j) +: 8], a4 ? "R5 address order" : "R4 address order",
          32'(rx[1+j]), 32'(adr[8*(hdr-2-j) +: 8]));
    for (int k = 0; k < 128; k++)
      chk(rx[hdr+k] === (8'(k) ^ seed), "R3 data byte order", 32'(rx[hdr+k]), 32'(8'(k) ^ seed));
    // R11: buffer empty after frame
    f0 = frames;
    bw(4'd0, 32'h10);
    br(4'd9, v);
    chk(v[0] === 1'b1, "R11 repeat start rejected", v, 1);
    repeat (20) @(negedge clk);
    chk(frames == f0, "R11 no frame sent", 32'(frames - f0), 0);
    bw(4'd9, 32'h1);
  endtask

  task automatic t_short();
    logic [31:0] v;
    int f0;
    bw(4'd1, 32'h1);
    fill(5, 8'h00);
    f0 = frames;
    bw(4'd0, 32'h10);
    br(4'd9, v);
    chk(v[0] === 1'b1, "R8 error flag set", v, 1);
    repeat (20) @(negedge clk);
    chk(frames == f0 && spi_cs_n === 1'b1, "R8 no frame", 32'(frames - f0), 0);
    bw(4'd9, 32'h1);
    br(4'd9, v);
    chk(v[0] === 1'b0, "R8 error cleared", v, 0);
  endtask

  task automatic t_single(input bit a4, input logic [7:0] d, input logic [31:0] adr);
    int hdr;
    hdr = a4 ? 5 : 4;
    set_hdr(8'h32, adr);
    bw(4'd1, {30'd0, a4, 1'b0});
    bw(4'd7, {24'd0, d});
    bw(4'd0, 32'h10);
    wait_idle();
    chk(last_len == hdr + 1, a4 ? "R5 single frame length" : "R6 single frame length", 32'(last_len), 32'(hdr + 1));
    chk(rx[0] === 8'h32, "R6 opcode", 32'(rx[0]), 32'h32);
    chk(rx[1] === adr[8*(hdr-2) +: 8], a4 ? "R5 top address byte" : "R6 top address byte", 32'(rx[1]), 32'(adr[8*(hdr-2) +: 8]));
    chk(rx[hdr] === d, "R6 data byte", 32'(rx[hdr]), 32'(d));
  endtask

  task automatic t_timing();
    realtime t1, t2;
    bw(4'd1, 32'h0);
    bw(4'd0, 32'h10);
    @(posedge spi_sclk); t1 = $realtime;
    @(posedge spi_sclk); t2 = $realtime;
    chk((t2 - t1) == 4.0 * 2 * HALF, "R10 bit period", 32'(int'(t2 - t1)), 32'(8 * HALF));
    wait_idle();
    repeat (5) @(negedge clk);
    chk(spi_sclk === 1'b0, "R10 idle clock low", 32'(spi_sclk), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_page(1'b0, 8'h5A, 32'h00_12_34_56);
    t_page(1'b1, 8'hC3, 32'h9A_BC_DE_F0);
    t_short();
    t_single(1'b0, 8'hA5, 32'h00_AB_CD_EF);
    t_single(1'b1, 8'h3C, 32'h81_42_24_18);
    t_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule